// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a synchronous host port and an external asynchronous static RAM of 256K words by 16 bits, with separate strobes for the low and high byte. The host raises a request with a word address, a write flag, write data and two byte enables. The controller then plays out a read or a write on the memory pins. Every interval is a whole number of clock cycles, worked out at elaboration time from the memory's nanosecond minimums and the clock period.

A read holds chip enable, output enable and the selected byte strobes low for a fixed access window. It captures the data on the last cycle of that window. A write first asserts chip enable and the byte strobes, then pulls read/write low, and drives the data bus only while read/write is low. After every access the controller waits out a standby turnaround so that the data bus changes direction cleanly. The host sees a single-cycle acknowledge when an access completes.

Top module: `sram_ctl`

## Requirements
- R1: While and after synchronous active-low reset, chip enable, output enable, read/write and both byte strobes are high, the acknowledge is low and the read data is zero.
- R2: Outside an access (idle and turnaround) chip enable and both byte strobes are high, so the memory is in standby.
- R3: A read holds chip enable low, output enable low, read/write high, the address equal to the host address and each byte strobe equal to the inverse of its enable. Output enable stays low for RD_CYC = max(1, ceil(55 ns / clock period)) cycles.
- R4: Read data is captured on the final cycle of the read window and is valid with the acknowledge. A lane whose enable is 0 returns zero. Lane 0 (enable bit 0, low strobe) is data bits 7:0, and lane 1 (enable bit 1, high strobe) is bits 15:8.
- R5: A write first holds chip enable and the selected strobes low with read/write high for SU_CYC cycles. It then holds read/write low for WP_CYC = max(1, ceil(40 ns / T), ceil(25 ns / T)) cycles. Output enable stays high for the whole write.
- R6: Chip enable is low for at least max(1, ceil(45 ns / T)) cycles when read/write rises. SU_CYC = max(1, CW_CYC - WP_CYC).
- R7: Only lanes whose enable is 1 are written. An access with both enables at 0 leaves memory unchanged. The write data and enables are latched at acceptance, and later host changes have no effect on that access.
- R8: The data bus is driven only while read/write is low. Output enable and read/write are never low together.
- R9: After each access the controller spends TA_CYC = max(1, ceil(25 ns / T)) standby cycles before it returns to idle. A request held through the access is ignored until then, so the next output enable falls TA_CYC+1 cycles after the acknowledge.
- R10: The acknowledge is high for exactly one cycle. It rises RD_CYC+1 cycles after the accepting edge for a read, and SU_CYC+WP_CYC+1 cycles after it for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Access request, sampled while idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 18 | Word address |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Byte enables, bit 0 = low byte |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Captured read data |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Read/write, low = write |
| mem_lb_n | output | 1 | Low byte strobe, active low |
| mem_ub_n | output | 1 | High byte strobe, active low |
| mem_addr | output | 18 | Memory word address |
| mem_dq | inout | 16 | Bidirectional data bus |

## Verification
The bench builds the controller with a 12 ns clock. That gives a 5-cycle read window, a 4-cycle write pulse and a 3-cycle turnaround. Because ceil(45/12) equals the pulse length, the setup count falls onto its one-cycle floor, so the clamp in the setup derivation is exercised. With these values the corner cases need only a handful of accesses: the top address, single-lane and empty enables, and a request held through an access.

// File: rtl/sram_ctl_pkg.sv
// Package: shared state encoding and cycle-count arithmetic for the SRAM controller.
// Assumes all nanosecond values and the clock period are positive integers.
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READ   = 3'd1,
        ST_WSETUP = 3'd2,
        ST_WPULSE = 3'd3,
        ST_TURN   = 3'd4
    } ctl_state_e;

    // Ceiling of ns/period, never below one cycle.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
        int unsigned q;
        q = (ns + period - 1) / period;
        return (q < 1) ? 1 : q;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
// Module: access sequencer. Accepts a host request only while idle, steps through the
// read window or the write setup/pulse phases, then a standby turnaround, using one
// down-counter. Control enables are decoded from the state register.
// Assumes every cycle count parameter is at least 1 and fits in CNT_W bits.
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int unsigned RD_CYC = 6,
    parameter int unsigned SU_CYC = 1,
    parameter int unsigned WP_CYC = 4,
    parameter int unsigned TA_CYC = 3,
    parameter int unsigned CNT_W  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic we,
    output logic accept,
    output logic ce_act,
    output logic oe_act,
    output logic we_act,
    output logic capture,
    output logic ack,
    output logic idle
);

    ctl_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_zero;

    assign cnt_zero = (cnt_q == '0);
    assign idle     = (state_q == ST_IDLE);
    assign accept   = idle && req;
    assign ce_act   = (state_q == ST_READ) || (state_q == ST_WSETUP) || (state_q == ST_WPULSE);
    assign oe_act   = (state_q == ST_READ);
    assign we_act   = (state_q == ST_WPULSE);
    assign capture  = (state_q == ST_READ) && cnt_zero;

    // Advance the access state, reload the phase counter and pulse the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            ack     <= 1'b0;
        end else begin
            ack <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req) begin
                        state_q <= we ? ST_WSETUP : ST_READ;
                        cnt_q   <= we ? CNT_W'(SU_CYC - 1) : CNT_W'(RD_CYC - 1);
                    end
                end
                ST_READ: begin
                    if (cnt_zero) begin
                        ack     <= 1'b1;
                        state_q <= ST_TURN;
                        cnt_q   <= CNT_W'(TA_CYC - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_WSETUP: begin
                    if (cnt_zero) begin
                        state_q <= ST_WPULSE;
                        cnt_q   <= CNT_W'(WP_CYC - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_WPULSE: begin
                    if (cnt_zero) begin
                        ack     <= 1'b1;
                        state_q <= ST_TURN;
                        cnt_q   <= CNT_W'(TA_CYC - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_TURN: begin
                    if (cnt_zero) begin
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    p_pulse_after_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WPULSE && $past(state_q) != ST_WPULSE) |-> $past(state_q) == ST_WSETUP);

    p_idle_after_turn_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $past(state_q) != ST_IDLE) |-> $past(state_q) == ST_TURN);

    p_ack_enters_turn_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> state_q == ST_TURN);

endmodule

// File: rtl/sram_ctl_lane.sv
// Module: one byte lane. Latches its enable and write byte at acceptance, produces the
// active-low lane strobe, drives its byte only during the write pulse, and captures the
// returned byte at the end of a read (zero when the lane is not enabled).
// Assumes accept, capture and the phase enables come from the sequencer.
module sram_ctl_lane #(
    parameter int unsigned LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              be_in,
    input  logic [LANE_W-1:0] wdata_in,
    input  logic              ce_act,
    input  logic              we_act,
    input  logic              capture,
    input  logic [LANE_W-1:0] dq_in,
    output logic              strobe_n,
    output logic              drive,
    output logic [LANE_W-1:0] dq_out,
    output logic [LANE_W-1:0] rdata
);

    logic              en_q;
    logic [LANE_W-1:0] wd_q;

    assign strobe_n = !(ce_act && en_q);
    assign drive    = we_act && en_q;
    assign dq_out   = wd_q;

    // Hold the lane enable and write byte for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            wd_q <= '0;
        end else if (accept) begin
            en_q <= be_in;
            wd_q <= wdata_in;
        end
    end

    // Sample the memory byte on the last read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (capture) begin
            rdata <= en_q ? dq_in : '0;
        end
    end

    p_strobe_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_act && $past(ce_act)) |-> $stable(strobe_n));

    p_drive_needs_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drive |-> !strobe_n);

endmodule

// File: rtl/sram_ctl.sv
// Module: top of the asynchronous SRAM byte-lane controller. Derives every cycle count
// from nanosecond minimums and the clock period, registers the address at acceptance,
// and joins the sequencer with one lane instance per byte.
// Assumes a 16-bit memory with exactly two byte lanes (low and high strobe).
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LANE_W = 8,
    parameter int unsigned CLK_NS = 10,
    parameter int unsigned RD_NS  = 55,
    parameter int unsigned WP_NS  = 40,
    parameter int unsigned CW_NS  = 45,
    parameter int unsigned DS_NS  = 25,
    parameter int unsigned TA_NS  = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [1:0]        host_be,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [DATA_W-1:0] mem_dq
);

    localparam int unsigned LANES  = DATA_W / LANE_W;
    localparam int unsigned RD_CYC = ns_to_cyc(RD_NS, CLK_NS);
    localparam int unsigned WP_CYC = max_u(ns_to_cyc(WP_NS, CLK_NS), ns_to_cyc(DS_NS, CLK_NS));
    localparam int unsigned CW_CYC = ns_to_cyc(CW_NS, CLK_NS);
    localparam int unsigned SU_CYC = (CW_CYC > WP_CYC) ? (CW_CYC - WP_CYC) : 1;
    localparam int unsigned TA_CYC = ns_to_cyc(TA_NS, CLK_NS);
    localparam int unsigned MAX_CYC = max_u(max_u(RD_CYC, WP_CYC), max_u(SU_CYC, TA_CYC));
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

    logic accept, ce_act, oe_act, we_act, capture, idle;
    logic [ADDR_W-1:0]             addr_q;
    logic [LANES-1:0]              strobe_n;
    logic [LANES-1:0]              drive;
    logic [LANES-1:0][LANE_W-1:0]  lane_out;
    logic [LANES-1:0][LANE_W-1:0]  lane_rd;

    sram_ctl_seq #(
        .RD_CYC (RD_CYC),
        .SU_CYC (SU_CYC),
        .WP_CYC (WP_CYC),
        .TA_CYC (TA_CYC),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (host_req),
        .we      (host_we),
        .accept  (accept),
        .ce_act  (ce_act),
        .oe_act  (oe_act),
        .we_act  (we_act),
        .capture (capture),
        .ack     (host_ack),
        .idle    (idle)
    );

    // Register the word address for the duration of the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (accept) begin
            addr_q <= host_addr;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_ctl_lane #(.LANE_W(LANE_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .accept   (accept),
            .be_in    (host_be[g]),
            .wdata_in (host_wdata[g*LANE_W +: LANE_W]),
            .ce_act   (ce_act),
            .we_act   (we_act),
            .capture  (capture),
            .dq_in    (mem_dq[g*LANE_W +: LANE_W]),
            .strobe_n (strobe_n[g]),
            .drive    (drive[g]),
            .dq_out   (lane_out[g]),
            .rdata    (lane_rd[g])
        );
        assign mem_dq[g*LANE_W +: LANE_W] = drive[g] ? lane_out[g] : {LANE_W{1'bz}};
        assign host_rdata[g*LANE_W +: LANE_W] = lane_rd[g];
    end

    assign mem_ce_n = !ce_act;
    assign mem_oe_n = !oe_act;
    assign mem_we_n = !we_act;
    assign mem_lb_n = strobe_n[0];
    assign mem_ub_n = strobe_n[LANES-1];
    assign mem_addr = addr_q;

    p_bus_vs_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|drive) |-> (mem_oe_n && !mem_we_n));

    p_idle_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (mem_ce_n && mem_lb_n && mem_ub_n));

    p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    p_write_keeps_oe_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_ce_n));

endmodule

// File: tb/sram_ctl_tb.sv
module sram_ctl_tb;

    localparam int CLK_NS = 12;

    function automatic int cyc(input int ns);
        int q;
        q = (ns + CLK_NS - 1) / CLK_NS;
        return (q < 1) ? 1 : q;
    endfunction

    localparam int RD_C = cyc(55);
    localparam int WP_C = (cyc(40) > cyc(25)) ? cyc(40) : cyc(25);
    localparam int CW_C = cyc(45);
    localparam int SU_C = (CW_C > WP_C) ? (CW_C - WP_C) : 1;
    localparam int TA_C = cyc(25);

    typedef struct packed {
        logic        we;
        logic [1:0]  be;
        logic [17:0] addr;
        logic [15:0] wd;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'b11, 18'h00010, 16'hA1B2, 16'h0000},
        '{1'b0, 2'b11, 18'h00010, 16'h0000, 16'hA1B2},
        '{1'b1, 2'b01, 18'h3FFFF, 16'h1234, 16'h0000},
        '{1'b0, 2'b11, 18'h3FFFF, 16'h0000, 16'h0034},
        '{1'b1, 2'b10, 18'h3FFFF, 16'hABCD, 16'h0000},
        '{1'b0, 2'b11, 18'h3FFFF, 16'h0000, 16'hAB34},
        '{1'b0, 2'b01, 18'h3FFFF, 16'h0000, 16'h0034},
        '{1'b0, 2'b10, 18'h3FFFF, 16'h0000, 16'hAB00},
        '{1'b1, 2'b00, 18'h00010, 16'hFFFF, 16'h0000},
        '{1'b0, 2'b11, 18'h00010, 16'h0000, 16'hA1B2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [17:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [1:0]  host_be = '0;
    logic        host_ack;
    logic [15:0] host_rdata;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
    logic [17:0] mem_addr;
    wire  [15:0] mem_dq;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_NS/2) clk = ~clk;

    sram_ctl #(.CLK_NS(CLK_NS)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_be    (host_be),
        .host_ack   (host_ack),
        .host_rdata (host_rdata),
        .mem_ce_n   (mem_ce_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_lb_n   (mem_lb_n),
        .mem_ub_n   (mem_ub_n),
        .mem_addr   (mem_addr),
        .mem_dq     (mem_dq)
    );

    // Memory model: 1024 words indexed by the low address bits.
    logic [15:0] mdl [1024];
    logic [15:0] mdl_rd;
    assign mdl_rd = mdl[mem_addr[9:0]];
    assign mem_dq[7:0]  = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_lb_n) ? mdl_rd[7:0]  : 8'hzz;
    assign mem_dq[15:8] = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_ub_n) ? mdl_rd[15:8] : 8'hzz;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) mdl[i] <= '0;
        end else if (!mem_ce_n && !mem_we_n) begin
            if (!mem_lb_n) mdl[mem_addr[9:0]][7:0]  <= mem_dq[7:0];
            if (!mem_ub_n) mdl[mem_addr[9:0]][15:8] <= mem_dq[15:8];
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Pin monitor: pulse widths and exclusivity.
    int wlen = 0, olen = 0, celen = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_oe_n && !mem_we_n) chk(1'b0, "R8 oe and we low together", 1, 0);
            if (mem_we_n && wlen != 0) begin
                chk(wlen == WP_C, "R5 write pulse width", wlen, WP_C);
                chk(celen >= CW_C && celen == SU_C + WP_C, "R6 ce low before we rise", celen, SU_C + WP_C);
            end
            if (mem_oe_n && olen != 0) chk(olen == RD_C, "R3 read window width", olen, RD_C);
            wlen  = mem_we_n ? 0 : wlen + 1;
            olen  = mem_oe_n ? 0 : olen + 1;
            celen = mem_ce_n ? 0 : celen + 1;
        end
    end

    task automatic run_vec(input vec_t v);
        int n;
        @(negedge clk);
        host_req = 1'b1; host_we = v.we; host_addr = v.addr; host_wdata = v.wd; host_be = v.be;
        @(negedge clk);
        host_req = 1'b0;
        host_wdata = ~v.wd;
        host_be = ~v.be;
        n = 1;
        chk(mem_ce_n == 1'b0 && mem_addr == v.addr, "R3 first cycle ce/addr", int'(mem_addr), int'(v.addr));
        chk({mem_ub_n, mem_lb_n} == ~v.be, "R7 lane strobes", {mem_ub_n, mem_lb_n}, ~v.be);
        if (v.we) chk(mem_oe_n && mem_we_n, "R5 setup phase oe/we high", {mem_oe_n, mem_we_n}, 3);
        else      chk(!mem_oe_n && mem_we_n, "R3 read oe low we high", {mem_oe_n, mem_we_n}, 1);
        while (!host_ack && n < 60) begin
            @(negedge clk);
            n++;
        end
        if (v.we) chk(n == SU_C + WP_C + 1, "R10 write ack latency", n, SU_C + WP_C + 1);
        else begin
            chk(n == RD_C + 1, "R10 read ack latency", n, RD_C + 1);
            chk(host_rdata == v.exp, "R4 read data", host_rdata, v.exp);
        end
        chk(mem_ce_n && mem_lb_n && mem_ub_n, "R2 standby in turnaround", {mem_ce_n, mem_lb_n, mem_ub_n}, 7);
        @(negedge clk);
        chk(!host_ack, "R10 ack one cycle", host_ack, 0);
        repeat (TA_C) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n, "R1 controls in reset",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n}, 31);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!host_ack && host_rdata == 16'h0, "R1 ack/rdata after reset", host_rdata, 0);
        chk(mem_ce_n && mem_lb_n && mem_ub_n, "R2 idle standby", {mem_ce_n, mem_lb_n, mem_ub_n}, 7);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R9: request held through a write is ignored until after turnaround.
        begin
            int m;
            @(negedge clk);
            host_req = 1'b1; host_we = 1'b1; host_addr = 18'h00123; host_wdata = 16'h5AA5; host_be = 2'b11;
            @(negedge clk);
            host_we = 1'b0; host_wdata = 16'hFFFF; host_addr = 18'h00123;
            while (!host_ack) @(negedge clk);
            m = 0;
            while (mem_oe_n && m < 20) begin
                @(negedge clk);
                m++;
            end
            chk(m == TA_C + 1, "R9 turnaround before held read", m, TA_C + 1);
            host_req = 1'b0;
            while (!host_ack) @(negedge clk);
            chk(host_rdata == 16'h5AA5, "R7 latched write data", host_rdata, 16'h5AA5);
        end
        repeat (TA_C + 2) @(negedge clk);
        finish_run();
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        finish_run();
    end

endmodule